// File: doc/BRIEF.md
# DMA Channel Activation Sequencer

This block turns a per-channel service request into one complete single-operand move. Requests come from hardware request lines or from a software start bit. The start bit is written through the same register port that loads the transfer descriptors. Pending requests are arbitrated. The winning channel's descriptor is fetched from a local memory built as 64-bit parts. The block then issues one source read and one destination write on a pipelined single-master bus. That bus stretches a data phase by holding its ready input low.

Activation follows a fixed pipeline that starts on the cycle a request is seen:

| Cycle after request | Stage |
|---|---|
| +1 | Request registered |
| +2, +3 | Arbitration |
| +4 to +7 | Descriptor parts arrive |

The bus read is issued alongside the third descriptor part. The destination write address goes out alongside the fourth part, during the read data phase. The move therefore starts before the whole descriptor has been read. Only one channel is active at a time. Requests that arrive meanwhile wait in the pending set until the sequencer is idle again.

Top module: `dma_act_seq`

## Requirements
- R1: A hardware request on `hw_req[c]` in cycle n, while the sequencer is idle with nothing pending, gives a read address phase in cycle n+6. That phase has `bus_valid`=1, `bus_write`=0, `bus_ready`=1 and `bus_addr` equal to the channel's source address.
- R2: A register write to word 7 of channel c with `reg_wdata[0]`=1 in cycle n starts channel c with the same timing as R1. The read address phase falls in cycle n+6. The same write with `reg_wdata[0]`=0 starts no transfer.
- R3: Of several pending channels, the highest index is served first. Each request produces exactly one activation, because a channel's pending bit is cleared when the channel is granted.
- R4: A request that arrives while a channel is active is kept pending. Let cycle X be the cycle in which the active write data phase completes with `bus_ready`=1. The next read address phase then falls in cycle X+6.
- R5: Descriptor fields for each channel are as follows:
  - Word 0 is the source address.
  - Bits 1:0 of word 1 are the size field, encoded as 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits.
  - Word 2 is the destination address.
  - On the bus, `bus_size` is 0 for byte, 1 for halfword and 2 for word.
- R6: The destination write address phase (`bus_write`=1) is the cycle right after the read address is accepted, and it stays up until the read data phase completes. `bus_wdata` in the following write data phase equals the data read.
- R7: While `bus_valid`=1 and `bus_ready`=0, `bus_valid`, `bus_addr` and `bus_write` keep their values into the next cycle.
- R8: Any access whose address has bits 31:28 equal to 4'hC (peripheral space) uses `bus_size`=2, whatever the size field holds.
- R9: After reset, `bus_valid` is 0 and no channel is pending, so no transfer starts until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 16 | Hardware service request, one bit per channel |
| reg_we | input | 1 | Descriptor register write strobe |
| reg_ch | input | 4 | Channel selected by the register write |
| reg_word | input | 3 | Descriptor word index (0 to 7) |
| reg_wdata | input | 32 | Register write data; bit 0 of word 7 is the start bit |
| bus_valid | output | 1 | Address phase valid |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Access address |
| bus_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | output | 32 | Write data, valid in the write data phase |
| bus_rdata | input | 32 | Read data, valid when the read data phase completes |
| bus_ready | input | 1 | High completes a data phase and accepts an address |

## Verification
The first read address of an activation is due 6 cycles after the request or start write, or 6 cycles after the previous write data phase completes. The write address is due in the cycle after the read address is accepted, plus the read wait states. The write completes one cycle plus the write wait states after that. The bench's bus model gives 2 wait states to peripheral reads and 3 to peripheral writes. A monitor notes the free-running cycle count at each of these events on the falling edge. It pops the expected activation from the scoreboard queue and compares each noted cycle with the value computed from the trigger cycle and the wait-state counts.

// File: rtl/dma_act_pkg.sv
package dma_act_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB1,
    ST_ARB2,
    ST_PART0,
    ST_PART1,
    ST_RD_ADDR,
    ST_RD_DATA,
    ST_WR_DATA
  } seq_st_e;

  localparam logic [1:0] BSZ_BYTE = 2'd0;
  localparam logic [1:0] BSZ_HALF = 2'd1;
  localparam logic [1:0] BSZ_WORD = 2'd2;

  function automatic logic [1:0] bus_size_of(input logic [1:0] fld, input logic periph);
    if (periph)
      return BSZ_WORD;
    case (fld)
      2'd0:    return BSZ_BYTE;
      2'd1:    return BSZ_HALF;
      default: return BSZ_WORD;
    endcase
  endfunction

endpackage

// File: rtl/dma_req_arb.sv
module dma_req_arb #(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_set,
  input  logic              clr_en,
  input  logic [CH_W-1:0]   clr_idx,
  output logic              pend_any,
  output logic [CH_W-1:0]   win_idx
);

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en)
      clr_mask[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pend <= '0;
    else
      pend <= (pend & ~clr_mask) | hw_req | sw_set;
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (pend[i])
        win_idx = CH_W'(i);
  end

  assign pend_any = |pend;

  AST_HIGHEST_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> ((pend >> clr_idx) == NUM_CH'(1)));  // R3

  AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !hw_req[clr_idx] && !sw_set[clr_idx]) |=> !pend[$past(clr_idx)]);  // R3

endmodule

// File: rtl/dma_desc_ram.sv
module dma_desc_ram #(
  parameter int NUM_CH     = 16,
  parameter int DW         = 32,
  parameter int DESC_WORDS = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PARTS  = DESC_WORDS / 2,
  localparam int PART_W = $clog2(PARTS),
  localparam int WSEL_W = $clog2(DESC_WORDS),
  localparam int DEPTH  = NUM_CH * PARTS
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DW-1:0]     wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [PART_W-1:0] rd_part,
  output logic [2*DW-1:0]   rd_data
);

  logic [CH_W+PART_W-1:0] wr_idx;
  logic [CH_W+PART_W-1:0] rd_idx;

  assign wr_idx = {wr_ch, wr_word[WSEL_W-1:1]};
  assign rd_idx = {rd_ch, rd_part};

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_word[0] == 1'(g)))
        mem[wr_idx] <= wr_data;
      rd_q <= mem[rd_idx];
    end

    assign rd_data[g*DW +: DW] = rd_q;
  end

endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
  import dma_act_pkg::*;
#(
  parameter int         NUM_CH     = 16,
  parameter int         DW         = 32,
  parameter int         DESC_WORDS = 8,
  parameter int         TAG_W      = 4,
  parameter logic [3:0] PERIPH_TAG = 4'hC,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PART_W = $clog2(DESC_WORDS / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_any,
  input  logic [CH_W-1:0]   win_idx,
  output logic              clr_en,
  output logic [CH_W-1:0]   rd_ch,
  output logic [PART_W-1:0] rd_part,
  input  logic [2*DW-1:0]   desc_part,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [DW-1:0]     bus_addr,
  output logic [1:0]        bus_size,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready
);

  seq_st_e       state;
  logic [CH_W-1:0] act_ch;
  logic [DW-1:0] src_q;
  logic [DW-1:0] dst_q;
  logic [1:0]    size_q;
  logic          unused_hi;

  assign unused_hi = ^desc_part[2*DW-1:DW+2];

  function automatic logic in_periph(input logic [DW-1:0] a);
    return a[DW-1 -: TAG_W] == PERIPH_TAG[TAG_W-1:0];
  endfunction

  always_comb begin
    clr_en = (state == ST_ARB1);
    rd_ch  = act_ch;
    case (state)
      ST_ARB2:  rd_part = PART_W'(0);
      ST_PART0: rd_part = PART_W'(1);
      ST_PART1: rd_part = PART_W'(2);
      default:  rd_part = PART_W'(3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      act_ch    <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      size_q    <= '0;
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= BSZ_BYTE;
      bus_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE:
          if (pend_any)
            state <= ST_ARB1;
        ST_ARB1: begin
          act_ch <= win_idx;
          state  <= ST_ARB2;
        end
        ST_ARB2:
          state <= ST_PART0;
        ST_PART0: begin
          src_q  <= desc_part[DW-1:0];
          size_q <= desc_part[DW+1:DW];
          state  <= ST_PART1;
        end
        ST_PART1: begin
          dst_q     <= desc_part[DW-1:0];
          bus_valid <= 1'b1;
          bus_write <= 1'b0;
          bus_addr  <= src_q;
          bus_size  <= bus_size_of(size_q, in_periph(src_q));
          state     <= ST_RD_ADDR;
        end
        ST_RD_ADDR:
          if (bus_ready) begin
            bus_write <= 1'b1;
            bus_addr  <= dst_q;
            bus_size  <= bus_size_of(size_q, in_periph(dst_q));
            state     <= ST_RD_DATA;
          end
        ST_RD_DATA:
          if (bus_ready) begin
            bus_valid <= 1'b0;
            bus_wdata <= bus_rdata;
            state     <= ST_WR_DATA;
          end
        ST_WR_DATA:
          if (bus_ready)
            state <= ST_IDLE;
        default:
          state <= ST_IDLE;
      endcase
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> ($past(state, 3) == ST_ARB2));  // R1

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));  // R7

  AST_PERIPH_WORD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && in_periph(bus_addr)) |-> (bus_size == BSZ_WORD));  // R8

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_ready) |=> (bus_valid && bus_write));  // R6

endmodule

// File: rtl/dma_act_seq.sv
module dma_act_seq #(
  parameter int         NUM_CH     = 16,
  parameter int         DW         = 32,
  parameter int         DESC_WORDS = 8,
  parameter int         TAG_W      = 4,
  parameter logic [3:0] PERIPH_TAG = 4'hC,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int WSEL_W = $clog2(DESC_WORDS),
  localparam int PART_W = $clog2(DESC_WORDS / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic              reg_we,
  input  logic [CH_W-1:0]   reg_ch,
  input  logic [WSEL_W-1:0] reg_word,
  input  logic [DW-1:0]     reg_wdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [DW-1:0]     bus_addr,
  output logic [1:0]        bus_size,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready
);

  localparam logic [WSEL_W-1:0] START_WORD = WSEL_W'(DESC_WORDS - 1);

  logic [NUM_CH-1:0] sw_set;
  logic              pend_any;
  logic [CH_W-1:0]   win_idx;
  logic              clr_en;
  logic [CH_W-1:0]   rd_ch;
  logic [PART_W-1:0] rd_part;
  logic [2*DW-1:0]   desc_part;

  always_comb begin
    sw_set = '0;
    if (reg_we && (reg_word == START_WORD) && reg_wdata[0])
      sw_set[reg_ch] = 1'b1;
  end

  dma_req_arb #(.NUM_CH(NUM_CH)) arb_i (
    .clk      (clk),
    .rst      (rst),
    .hw_req   (hw_req),
    .sw_set   (sw_set),
    .clr_en   (clr_en),
    .clr_idx  (win_idx),
    .pend_any (pend_any),
    .win_idx  (win_idx)
  );

  dma_desc_ram #(.NUM_CH(NUM_CH), .DW(DW), .DESC_WORDS(DESC_WORDS)) ram_i (
    .clk     (clk),
    .wr_en   (reg_we),
    .wr_ch   (reg_ch),
    .wr_word (reg_word),
    .wr_data (reg_wdata),
    .rd_ch   (rd_ch),
    .rd_part (rd_part),
    .rd_data (desc_part)
  );

  dma_xfer_ctl #(
    .NUM_CH(NUM_CH), .DW(DW), .DESC_WORDS(DESC_WORDS),
    .TAG_W(TAG_W), .PERIPH_TAG(PERIPH_TAG)
  ) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .pend_any  (pend_any),
    .win_idx   (win_idx),
    .clr_en    (clr_en),
    .rd_ch     (rd_ch),
    .rd_part   (rd_part),
    .desc_part (desc_part),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready)
  );

endmodule

// File: tb/dma_act_seq_tb.sv
module dma_act_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] hw_req = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_ch = '0;
  logic [2:0]  reg_word = '0;
  logic [31:0] reg_wdata = '0;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        bus_ready;

  always #10 clk = ~clk;

  dma_act_seq dut_i (
    .clk(clk), .rst(rst), .hw_req(hw_req), .reg_we(reg_we), .reg_ch(reg_ch),
    .reg_word(reg_word), .reg_wdata(reg_wdata), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // bus model: peripheral reads 2 wait states, peripheral writes 3, memory none
  logic        dp_active = 1'b0;
  logic        dp_write = 1'b0;
  logic [31:0] dp_addr = '0;
  int          dp_wait = 0;

  function automatic bit is_per(input logic [31:0] a);
    return a[31:28] == 4'hC;
  endfunction
  function automatic int waits_of(input logic [31:0] a, input logic w);
    return is_per(a) ? (w ? 3 : 2) : 0;
  endfunction
  function automatic logic [31:0] rd_val(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic logic [1:0] exp_size(input logic [1:0] f, input logic [31:0] a);
    if (is_per(a)) return 2'd2;
    return (f >= 2'd2) ? 2'd2 : f;
  endfunction

  assign bus_ready = !dp_active || (dp_wait == 0);
  assign bus_rdata = rd_val(dp_addr);

  always @(posedge clk) begin
    if (rst) begin
      dp_active <= 1'b0;
      dp_wait   <= 0;
    end else if (bus_ready) begin
      dp_active <= bus_valid;
      dp_write  <= bus_write;
      dp_addr   <= bus_addr;
      dp_wait   <= bus_valid ? waits_of(bus_addr, bus_write) : 0;
    end else begin
      dp_wait <= dp_wait - 1;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  typedef struct {
    int          ch;
    logic [31:0] src, dst;
    logic [1:0]  rsz, wsz;
    bit          follow;
    int          t;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] m_src[16];
  logic [31:0] m_dst[16];
  logic [1:0]  m_sz[16];

  // monitor
  int          rd_cyc, wa_cyc, last_done = -100;
  logic [31:0] g_raddr, g_waddr, hold_addr;
  logic [1:0]  g_rsz, g_wsz;
  bit          hold_flag = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (hold_flag)
        chk(bus_valid && bus_addr == hold_addr, "R7 hold", bus_addr, hold_addr);
      hold_flag = bus_valid && !bus_ready;
      hold_addr = bus_addr;
      if (bus_valid && bus_ready && !bus_write) begin
        rd_cyc = cyc; g_raddr = bus_addr; g_rsz = bus_size;
      end
      if (bus_valid && bus_ready && bus_write) begin
        wa_cyc = cyc; g_waddr = bus_addr; g_wsz = bus_size;
      end
      if (dp_active && dp_write && bus_ready) begin
        if (q.size() == 0) begin
          chk(0, "R3 unexpected activation", g_raddr, 0);
        end else begin
          exp_t e;
          int er;
          e = q.pop_front();
          er = e.follow ? last_done + 6 : e.t + 6;
          chk(rd_cyc == er, {e.tag, " read cycle"}, rd_cyc, er);
          chk(g_raddr == e.src, "R5 source address", g_raddr, e.src);
          chk(g_rsz == e.rsz, "R5/R8 read size", {30'd0, g_rsz}, {30'd0, e.rsz});
          chk(g_waddr == e.dst, "R5 destination address", g_waddr, e.dst);
          chk(g_wsz == e.wsz, "R5/R8 write size", {30'd0, g_wsz}, {30'd0, e.wsz});
          chk(wa_cyc == rd_cyc + 1 + waits_of(e.src, 1'b0), "R6 write address cycle",
              wa_cyc, rd_cyc + 1 + waits_of(e.src, 1'b0));
          chk(cyc == wa_cyc + 1 + waits_of(e.dst, 1'b1), "R6 write done cycle",
              cyc, wa_cyc + 1 + waits_of(e.dst, 1'b1));
          chk(bus_wdata == rd_val(e.src), "R6 write data", bus_wdata, rd_val(e.src));
        end
        last_done = cyc;
      end
    end
  end

  task automatic reg_wr(input int ch, input int w, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 4'(ch); reg_word = 3'(w); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [1:0] sz);
    reg_wr(ch, 0, s);
    reg_wr(ch, 1, {30'h3FFF_FFF0 >> 2, sz});
    reg_wr(ch, 2, d);
    m_src[ch] = s; m_dst[ch] = d; m_sz[ch] = sz;
  endtask

  function automatic exp_t mk(input int ch, input bit fol, input int t, input string tag);
    exp_t e;
    e.ch = ch; e.src = m_src[ch]; e.dst = m_dst[ch];
    e.rsz = exp_size(m_sz[ch], m_src[ch]);
    e.wsz = exp_size(m_sz[ch], m_dst[ch]);
    e.follow = fol; e.t = t; e.tag = tag;
    return e;
  endfunction

  task automatic wait_drain();
    for (int i = 0; i < 400 && (q.size() != 0 || bus_valid); i++)
      @(negedge clk);
    chk(q.size() == 0, "R3 all activations seen", q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bus_valid) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_valid == 1'b0, "R9 bus idle after reset", bus_valid, 0);
    quiet(12, "R9 nothing pending after reset");

    prog(3,  32'h1000_0010, 32'hC000_0020, 2'd0);
    prog(5,  32'hC000_0100, 32'h2000_0040, 2'd1);
    prog(9,  32'h1000_0800, 32'h1000_0900, 2'd2);
    prog(15, 32'h3000_0004, 32'hC000_0008, 2'd1);
    prog(0,  32'hC000_0030, 32'hC000_0034, 2'd3);

    // R1: single hardware request from idle
    @(negedge clk);
    q.push_back(mk(3, 0, cyc, "R1"));
    hw_req = 16'h0008;
    @(negedge clk);
    hw_req = '0;
    wait_drain();

    // R2: software start bit
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 4'd5; reg_word = 3'd7; reg_wdata = 32'h1;
    q.push_back(mk(5, 0, cyc, "R2"));
    @(negedge clk);
    reg_we = 1'b0;
    wait_drain();

    // R2: start bit clear starts nothing
    reg_wr(9, 7, 32'hFFFF_FFFE);
    quiet(20, "R2 start bit clear ignored");

    // R3: simultaneous requests served highest index first
    @(negedge clk);
    q.push_back(mk(15, 0, cyc, "R3 first"));
    q.push_back(mk(9,  1, 0,   "R3 second"));
    q.push_back(mk(0,  1, 0,   "R3 third"));
    hw_req = 16'h8201;
    @(negedge clk);
    hw_req = '0;
    wait_drain();

    // R4: request arriving while a channel is active waits
    @(negedge clk);
    q.push_back(mk(5, 0, cyc, "R4 active"));
    q.push_back(mk(3, 1, 0,   "R4 queued"));
    hw_req = 16'h0020;
    @(negedge clk);
    hw_req = '0;
    repeat (3) @(negedge clk);
    hw_req = 16'h0008;
    @(negedge clk);
    hw_req = '0;
    wait_drain();

    // R5: rewritten descriptor fields take effect
    prog(9, 32'h1000_0A02, 32'hC000_0A10, 2'd1);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 4'd9; reg_word = 3'd7; reg_wdata = 32'h1;
    q.push_back(mk(9, 0, cyc, "R5 R2 rewritten"));
    @(negedge clk);
    reg_we = 1'b0;
    wait_drain();

    quiet(10, "R3 no repeat activation");
    summary();
    $finish;
  end

endmodule